// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects the interrupt inputs of a small 8-bit processor core and turns them into one request with a 16-bit restart address. It has one non-maskable trap input, three maskable restart inputs (named 5.5, 6.5 and 7.5 after their restart slots) and a general request input. The general request has no fixed address: the core fetches its opcode from an external device, and this block answers it with an acknowledge pulse. The 5.5 and 6.5 inputs act on their level. The 7.5 input acts on a rising edge, which is held in a flip-flop until the interrupt is serviced or cleared. The trap input is taken on a rising edge, and only while it is still high.

The core controls the block through plain control pins. An enable command arms the global enable, which takes effect only when the next instruction has finished. A disable command clears it at once. Every accepted interrupt also clears it. A one-cycle write strobe delivers a mask-set byte. The write port is always ready and accepts a byte in any cycle in which the strobe is high, so it has no back-pressure. A status byte is always present on an output. The core accepts the presented request by raising its take pin while the request is high. The request and the address are combinational from the registered state and the level inputs, so they drop in the cycle after a take.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, no request is presented, the status byte reads 0x07 with the serial input low, and the serial output is 0.
- R2: The restart address is 0x0024 for trap, 0x002C for 5.5, 0x0034 for 6.5 and 0x003C for 7.5, which is 0x0024 plus 8 times the slot index 0 to 3. A general request shows address 0x0000 with the external-opcode flag set.
- R3: When several sources are eligible, the winner is trap, then 7.5, then 6.5, then 5.5, then the general request.
- R4: The 5.5 and 6.5 inputs request while they are high and stop as soon as they go low, with no memory of the input.
- R5: A rising edge on the 7.5 input sets a pending flip-flop one clock later. The flip-flop stays set after the input falls and clears on acceptance of 7.5, on a mask write with bit 4 set, and on reset.
- R6: The trap input ignores the global enable and the masks. It requests from the clock after a rising edge for as long as it stays high. Once accepted, it requests again only after it has fallen and risen again.
- R7: On a mask-write strobe, when bit 3 is 1, bits 2..0 load the masks for 5.5, 6.5 and 7.5, where 1 blocks the input. When bit 3 is 0, the masks are left alone. When bit 6 is 1, bit 7 loads the serial output. When bit 6 is 0, the serial output is kept.
- R8: The status byte reads {serial input pin, 7.5 pending, 6.5 level, 5.5 level, global enable, masks[2:0]}, from bit 7 down to bit 0.
- R9: Raising take while a request is presented accepts it, and the global enable reads 0 from the next clock.
- R10: An enable command sets the global enable on the first instruction-done pulse in a later cycle. A disable command clears the enable at once and cancels an armed enable.
- R11: The acknowledge output is high exactly while take accepts a general request.
- R12: No maskable or general request is presented while the global enable is 0, and no masked restart input is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap input |
| r55_in | input | 1 | Level-sensitive restart 5.5 |
| r65_in | input | 1 | Level-sensitive restart 6.5 |
| r75_in | input | 1 | Edge-sensitive restart 7.5 |
| ext_req_in | input | 1 | General request |
| ext_ack_out | output | 1 | Acknowledge of a general request |
| mw_valid | input | 1 | Mask-write strobe (always accepted) |
| mw_data | input | 8 | Mask-write byte |
| en_cmd | input | 1 | Enable command executed |
| dis_cmd | input | 1 | Disable command executed |
| insn_done | input | 1 | Instruction boundary |
| take | input | 1 | Core accepts the presented request |
| ser_in | input | 1 | Serial input pin, reported in status |
| ser_out | output | 1 | Serial output bit |
| status_out | output | 8 | Status byte |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 16 | Restart address |
| irq_ext | output | 1 | Request needs an external opcode |

## Verification
The case that is hardest to reach from the ports is a trap pulse that falls before the core takes it, together with a trap that is still held high after being taken. The stimulus raises trap for exactly one clock and then checks two cycles later that no request has appeared. The bench also sweeps every mask value against every mix of 5.5 and 6.5 levels, 7.5 pending and general request, with the enable both on and off. For each point it first clears the 7.5 flip-flop through bit 4 of the mask write and then sets it again with a single rising edge. The one-instruction enable delay is exercised with the enable command and an instruction boundary in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int MW_APPLY = 3;
  localparam int MW_CLR75 = 4;
  localparam int MW_SOE   = 6;
  localparam int MW_SOD   = 7;
  localparam int NSRC     = 5;
  localparam int S_TRAP = 0;
  localparam int S_R75  = 1;
  localparam int S_R65  = 2;
  localparam int S_R55  = 3;
  localparam int S_GEN  = 4;
endpackage

// File: rtl/irqc_edge_flop.sv
module irqc_edge_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic q
);
  logic prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      q    <= 1'b0;
    end else begin
      prev <= din;
      if (din && !prev) q <= 1'b1;
      else if (clr)     q <= 1'b0;
    end
  end

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    q && !clr |=> q); // R5
endmodule

// File: rtl/irqc_trap_qual.sv
module irqc_trap_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  input  logic taken,
  output logic req
);
  logic prev, lat;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      lat  <= 1'b0;
    end else begin
      prev <= trap_in;
      if (trap_in && !prev)      lat <= 1'b1;
      else if (!trap_in || taken) lat <= 1'b0;
    end
  end
  assign req = lat & trap_in;

  AST_TRAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !req); // R6
endmodule

// File: rtl/irqc_ctl_regs.sv
module irqc_ctl_regs
  import irqc_pkg::*;
#(
  parameter int NUM_MASK = 3,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                en_cmd,
  input  logic                dis_cmd,
  input  logic                insn_done,
  input  logic                accept,
  output logic [NUM_MASK-1:0] mask,
  output logic                ie,
  output logic                clr75,
  output logic                sout
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '1;
      ie    <= 1'b0;
      armed <= 1'b0;
      sout  <= 1'b0;
    end else begin
      if (wr_valid && wr_data[MW_APPLY]) mask <= wr_data[NUM_MASK-1:0];
      if (wr_valid && wr_data[MW_SOE])   sout <= wr_data[MW_SOD];
      if (accept || dis_cmd) begin
        ie    <= 1'b0;
        armed <= 1'b0;
      end else if (en_cmd) begin
        armed <= 1'b1;
      end else if (armed && insn_done) begin
        ie    <= 1'b1;
        armed <= 1'b0;
      end
    end
  end

  assign clr75 = wr_valid & wr_data[MW_CLR75];

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_data[MW_APPLY]) |=> $stable(mask)); // R7
  AST_IE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie) |-> $past(insn_done) && !$past(en_cmd)); // R10
  AST_ACCEPT_IE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie); // R9
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] sel,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_stage
    assign sel[i]    = cand[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cand[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0024,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_in,
  input  logic              r55_in,
  input  logic              r65_in,
  input  logic              r75_in,
  input  logic              ext_req_in,
  output logic              ext_ack_out,
  input  logic              mw_valid,
  input  logic [7:0]        mw_data,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              insn_done,
  input  logic              take,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [7:0]        status_out,
  output logic              irq_req,
  output logic [ADDR_W-1:0] irq_vec,
  output logic              irq_ext
);
  localparam int NUM_MASK = 3;

  logic [NUM_MASK-1:0] mask;
  logic                ie, clr75, p75, trap_req, accept;
  logic [NSRC-1:0]     cand, sel;

  assign accept = take & irq_req;

  irqc_ctl_regs #(.NUM_MASK(NUM_MASK), .BYTE_W(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(mw_valid), .wr_data(mw_data),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .insn_done(insn_done),
    .accept(accept), .mask(mask), .ie(ie), .clr75(clr75), .sout(ser_out)
  );

  irqc_edge_flop u_r75 (
    .clk(clk), .rst_n(rst_n), .din(r75_in),
    .clr(clr75 | (accept & sel[S_R75])), .q(p75)
  );

  irqc_trap_qual u_trap (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in),
    .taken(accept & sel[S_TRAP]), .req(trap_req)
  );

  assign cand[S_TRAP] = trap_req;
  assign cand[S_R75]  = ie & ~mask[2] & p75;
  assign cand[S_R65]  = ie & ~mask[1] & r65_in;
  assign cand[S_R55]  = ie & ~mask[0] & r55_in;
  assign cand[S_GEN]  = ie & ext_req_in;

  irqc_prio #(.N(NSRC)) u_prio (.cand(cand), .sel(sel), .any(irq_req));

  // restart slot: trap 0, 5.5 1, 6.5 2, 7.5 3
  always_comb begin
    logic [15:0] slot;
    slot = 16'd0;
    if (sel[S_R55]) slot = 16'd1;
    if (sel[S_R65]) slot = 16'd2;
    if (sel[S_R75]) slot = 16'd3;
    if (irq_req && !sel[S_GEN]) irq_vec = ADDR_W'(VEC_BASE + VEC_STEP * slot);
    else                        irq_vec = '0;
  end

  assign irq_ext     = sel[S_GEN];
  assign ext_ack_out = accept & sel[S_GEN];
  assign status_out  = {ser_in, p75, r65_in, r55_in, ie, mask};

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R3
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> irq_req && irq_vec == ADDR_W'(VEC_BASE)); // R3
  AST_ACK_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack_out |-> irq_ext && take); // R11
  AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie && !trap_req |-> !irq_req); // R12
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_in = 0, r55_in = 0, r65_in = 0, r75_in = 0, ext_req_in = 0;
  logic mw_valid = 0, en_cmd = 0, dis_cmd = 0, insn_done = 0, take = 0, ser_in = 0;
  logic [7:0] mw_data = 8'h00;
  logic ext_ack_out, ser_out, irq_req, irq_ext;
  logic [7:0] status_out;
  logic [15:0] irq_vec;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .r55_in(r55_in),
    .r65_in(r65_in), .r75_in(r75_in), .ext_req_in(ext_req_in),
    .ext_ack_out(ext_ack_out), .mw_valid(mw_valid), .mw_data(mw_data),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .insn_done(insn_done), .take(take),
    .ser_in(ser_in), .ser_out(ser_out), .status_out(status_out),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ext(irq_ext)
  );

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mwrite(input logic [7:0] d);
    mw_valid = 1'b1; mw_data = d; tick(); mw_valid = 1'b0; mw_data = 8'h00;
  endtask

  task automatic enable_now();
    en_cmd = 1'b1; tick(); en_cmd = 1'b0;
    insn_done = 1'b1; tick(); insn_done = 1'b0;
  endtask

  task automatic pulse75();
    r75_in = 1'b1; tick(); r75_in = 1'b0;
  endtask

  // {req, ext, vec}
  function automatic logic [17:0] expect_out(input logic tr, input logic ien,
      input logic [2:0] m, input logic p75, input logic l65, input logic l55, input logic g);
    if (tr)                    return {2'b10, 16'h0024};
    if (ien && p75 && !m[2])   return {2'b10, 16'h0024 + 16'd8 * 16'd3};
    if (ien && l65 && !m[1])   return {2'b10, 16'h0024 + 16'd8 * 16'd2};
    if (ien && l55 && !m[0])   return {2'b10, 16'h0024 + 16'd8 * 16'd1};
    if (ien && g)              return {2'b11, 16'h0000};
    return 18'd0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    #2;
    chk("R1 req", {17'd0, irq_req}, 18'd0);
    chk("R1 status", {10'd0, status_out}, 18'h07);
    chk("R1 sout", {17'd0, ser_out}, 18'd0);
    tick();

    // R12: disabled after reset, unmasked 5.5 level gives nothing
    mwrite(8'h08);
    r55_in = 1'b1; #2;
    chk("R12 disabled", {17'd0, irq_req}, 18'd0);
    r55_in = 1'b0; tick();

    // sweep: enable x mask x {gen,55,65,75}; R2 R3 R4 R8 R12
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 8; m++) begin
        for (int p = 0; p < 16; p++) begin
          mwrite(8'h18 | 8'(m));
          if (p[0]) pulse75();
          if (e == 1) enable_now();
          else begin dis_cmd = 1'b1; tick(); dis_cmd = 1'b0; end
          r65_in = p[1]; r55_in = p[2]; ext_req_in = p[3]; ser_in = p[1] ^ m[0];
          #2;
          chk("R3 R2 R12 sweep", {irq_req, irq_ext, irq_vec},
              expect_out(1'b0, e[0], 3'(m), p[0], p[1], p[2], p[3]));
          chk("R8 status", {10'd0, status_out},
              {10'd0, ser_in, p[0], p[1], p[2], e[0], 3'(m)});
          tick();
          r65_in = 1'b0; r55_in = 1'b0; ext_req_in = 1'b0; ser_in = 1'b0;
          #2;
          if (!p[0] || m[2] || e == 0)
            chk("R4 level drop", {17'd0, irq_req}, 18'd0);
        end
      end
    end

    // R6 trap: ignores enable/mask, once per edge, glitch rejected
    dis_cmd = 1'b1; mwrite(8'h1F); dis_cmd = 1'b0;
    trap_in = 1'b1; tick(); #2;
    chk("R6 trap req", {irq_req, irq_ext, irq_vec}, {2'b10, 16'h0024});
    take = 1'b1; tick(); take = 1'b0; #2;
    chk("R6 trap held", {17'd0, irq_req}, 18'd0);
    trap_in = 1'b0; tick(); trap_in = 1'b1; tick(); #2;
    chk("R6 trap rearm", {17'd0, irq_req}, 18'd1);
    take = 1'b1; tick(); take = 1'b0; trap_in = 1'b0; tick();
    trap_in = 1'b1; tick(); trap_in = 1'b0; #2;
    chk("R6 glitch", {17'd0, irq_req}, 18'd0);
    tick(); #2;
    chk("R6 glitch later", {17'd0, irq_req}, 18'd0);

    // R3 trap beats everything
    mwrite(8'h08); enable_now(); pulse75();
    r55_in = 1'b1; r65_in = 1'b1; ext_req_in = 1'b1; trap_in = 1'b1; tick(); #2;
    chk("R3 trap wins", {irq_req, irq_ext, irq_vec}, {2'b10, 16'h0024});
    trap_in = 1'b0; r55_in = 1'b0; r65_in = 1'b0; ext_req_in = 1'b0;
    take = 1'b1; tick(); take = 1'b0; #2;
    chk("R9 ie cleared by trap", {17'd0, status_out[3]}, 18'd0);

    // R5: 7.5 held, cleared by accept, cleared by bit4
    mwrite(8'h18); pulse75(); repeat (3) tick(); #2;
    chk("R5 held", {17'd0, status_out[6]}, 18'd1);
    chk("R12 pending disabled", {17'd0, irq_req}, 18'd0);
    enable_now(); #2;
    chk("R5 vec", {irq_req, irq_ext, irq_vec}, {2'b10, 16'h003C});
    take = 1'b1; tick(); take = 1'b0; #2;
    chk("R5 accept clears", {17'd0, status_out[6]}, 18'd0);
    chk("R9 ie off", {17'd0, status_out[3]}, 18'd0);
    mwrite(8'h0D); pulse75();
    mwrite(8'h12); #2;
    chk("R5 bit4 clears", {17'd0, status_out[6]}, 18'd0);
    chk("R7 masks kept", {15'd0, status_out[2:0]}, 18'h5);

    // R7 serial output
    mwrite(8'hC0); #2; chk("R7 sout set", {17'd0, ser_out}, 18'd1);
    mwrite(8'h80); mwrite(8'h00); #2; chk("R7 sout kept", {17'd0, ser_out}, 18'd1);
    mwrite(8'h40); #2; chk("R7 sout clear", {17'd0, ser_out}, 18'd0);

    // R10 enable delay
    en_cmd = 1'b1; insn_done = 1'b1; tick(); en_cmd = 1'b0; insn_done = 1'b0; #2;
    chk("R10 same cycle", {17'd0, status_out[3]}, 18'd0);
    repeat (2) tick(); #2;
    chk("R10 waits", {17'd0, status_out[3]}, 18'd0);
    insn_done = 1'b1; tick(); insn_done = 1'b0; #2;
    chk("R10 after next", {17'd0, status_out[3]}, 18'd1);
    dis_cmd = 1'b1; tick(); dis_cmd = 1'b0; #2;
    chk("R10 disable", {17'd0, status_out[3]}, 18'd0);
    en_cmd = 1'b1; tick(); en_cmd = 1'b0;
    dis_cmd = 1'b1; tick(); dis_cmd = 1'b0;
    insn_done = 1'b1; tick(); insn_done = 1'b0; #2;
    chk("R10 cancel", {17'd0, status_out[3]}, 18'd0);

    // R11 general request acknowledge
    enable_now(); ext_req_in = 1'b1; #2;
    chk("R11 ext flag", {irq_req, irq_ext, irq_vec}, {2'b11, 16'h0000});
    chk("R11 no ack idle", {17'd0, ext_ack_out}, 18'd0);
    take = 1'b1; #1;
    chk("R11 ack", {17'd0, ext_ack_out}, 18'd1);
    tick(); take = 1'b0; #2;
    chk("R11 ack ends", {17'd0, ext_ack_out}, 18'd0);
    chk("R9 req drops", {17'd0, irq_req}, 18'd0);
    ext_req_in = 1'b0; tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule